// File: doc/BRIEF.md
# Calendar Counter with Alarm and Update Cycle

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, weekday, day of month, month and full year as binary counters and moves them forward by one second on each one-second tick. The counters move only while the oscillator divider field selects the running reference. Each counted second opens an update cycle. The busy bit rises at once. After a fixed number of microsecond ticks the new time is written out as register bytes and the busy bit drops. The bytes are in packed-decimal or plain binary form, and the hour is in 24-hour or 12-hour form.

The alarm is checked at the end of the same update cycle. An update-ended indication may be raised there as well. Both leave the block as a one-cycle mask that the surrounding status register ORs into itself. Host software commits a new time through the load port as register bytes in the current format. The block decodes those bytes into its binary counters and shows them on its outputs at once. The host bus, the status register itself and the periodic-interrupt divider sit outside the block.

Top module: `rtc_calendar_core`

## Requirements
- R1: On each counted second, seconds wrap 59 to 0 and carry into minutes, minutes wrap 59 to 0 and carry into hours, and hours wrap 23 to 0 and advance the day. The weekday goes up by one with each new day and wraps from 6 to 0.
- R2: The day of month wraps to 1 after the last day of the month, and the month then advances. Month lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12 and 30 for months 4, 6, 9 and 11. December wraps to January of the next year. `year_o` shows the year modulo 100. The month is shown one-based.
- R3: February has 29 days when the year is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28.
- R4: A `sec_tick` counts only when `div_sel` equals 3'b010. With any other value the time does not move and no update cycle starts.
- R5: A counted tick sets `busy` on the next clock edge unless `set_mode` is high. After `DELAY_US` further `us_tick` pulses, the outputs take the new time and `busy` clears on the same edge.
- R6: While `set_mode` is high, no update cycle raises `busy` and nothing is written to the time outputs. The counters keep advancing, so the next publish after `set_mode` drops shows every second counted in the meantime.
- R7: With `bin_mode` low, each byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. With `bin_mode` high, each byte holds the binary value.
- R8: With `h24_mode` low, the hour byte holds the hour modulo 12 (so 0 at midnight and at noon), with bit 7 set for hours 12 to 23.
- R9: A `load_en` pulse decodes the seven `ld_*` bytes in the current format into the counters. In 12-hour mode, bit 7 of `ld_hr` adds 12 hours. The year becomes `YEAR_BASE` plus the decoded value. The outputs show the loaded bytes on the next edge. A load in the same cycle as a tick wins, and that tick is dropped.
- R10: At the end of each update cycle, if `alarm_ie` is high and each of `alm_sec`, `alm_min` and `alm_hr` either decodes to the current value or has bits 7:6 both set, `flag_or` carries 8'hA0.
- R11: At the end of each update cycle, if `upd_ie` is high and `set_mode` is low, `flag_or` carries 8'h90. This is ORed with any alarm mask, so both together give 8'hB0.
- R12: `flag_or` is non-zero for exactly one cycle per update cycle and is zero at all other times.
- R13: After reset the outputs show 00:00:00, weekday 0, day 01, month 01 and year 00. `busy` and `flag_or` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per second |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| div_sel | input | 3 | Divider field; 3'b010 means running |
| set_mode | input | 1 | Freezes publishing of the time |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed decimal |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit 7 |
| upd_ie | input | 1 | Update-ended indication enable |
| alarm_ie | input | 1 | Alarm indication enable |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte (24-hour value) |
| load_en | input | 1 | Commits the `ld_*` bytes |
| ld_sec | input | 8 | Seconds byte to load |
| ld_min | input | 8 | Minutes byte to load |
| ld_hr | input | 8 | Hours byte to load |
| ld_wday | input | 8 | Weekday byte to load |
| ld_mday | input | 8 | Day-of-month byte to load |
| ld_mon | input | 8 | Month byte to load |
| ld_year | input | 8 | Year byte to load |
| sec_o | output | 8 | Published seconds |
| min_o | output | 8 | Published minutes |
| hr_o | output | 8 | Published hours |
| wday_o | output | 8 | Published weekday |
| mday_o | output | 8 | Published day of month |
| mon_o | output | 8 | Published month |
| year_o | output | 8 | Published year modulo 100 |
| busy | output | 1 | Update cycle in progress |
| flag_or | output | 8 | One-cycle mask to OR into status |

## Verification
A wrong carry or a wrong month length stays hidden until an update cycle. It then shows as a wrong byte on the outputs, `DELAY_US` microsecond ticks after the tick that caused it. Because the bench loads the time just before each boundary, such errors appear within one update cycle of the stimulus. A sequencer fault shows up in different ways. It can make `busy` last the wrong number of cycles. It can make a publish happen during set mode, which the scoreboard reports as an item it did not expect. It can also leave `flag_or` high for a second cycle. The alarm comparators show their faults in the `flag_or` value read at the edge where `busy` falls.

// File: rtl/rtc_cal_pkg.sv
// Shared types and byte conversions for the calendar counter.
// Assumes packed-decimal bytes hold valid digits; other values decode modulo 128.
package rtc_cal_pkg;

    // Divider field value that lets time run
    localparam logic [2:0] DIV_RUN = 3'b010;

    // Binary calendar state
    typedef struct packed {
        logic [6:0]  sec;
        logic [6:0]  min;
        logic [4:0]  hr;
        logic [2:0]  wday;
        logic [4:0]  mday;
        logic [3:0]  mon;
        logic [11:0] year;
    } cal_time_t;

    // Binary value to a register byte in the selected number form
    function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    // Register byte in the selected number form to a binary value
    function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
        logic [7:0] t;
        t = 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
        return bin ? b[6:0] : t[6:0];
    endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
// Binary calendar counter: advances one second per adv pulse with full
// Gregorian leap handling, or takes a decoded time from ld_time.
// Assumes adv and ld are single-cycle strobes; ld has priority.
module rtc_cal_counter
    import rtc_cal_pkg::*;
#(
    parameter int YEAR_BASE = 2000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      ld,
    input  cal_time_t ld_time,
    output cal_time_t now
);

    cal_time_t  nxt;
    logic       leap;
    logic [4:0] dim;

    // Leap year and month length for the current month
    always_comb begin
        leap = ((now.year % 12'd4) == 12'd0) &&
               (((now.year % 12'd100) != 12'd0) || ((now.year % 12'd400) == 12'd0));
        case (now.mon)
            4'd2:                       dim = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    dim = 5'd30;
            default:                    dim = 5'd31;
        endcase
    end

    // Next-second carry chain
    always_comb begin
        nxt = now;
        if (now.sec >= 7'd59) begin
            nxt.sec = '0;
            if (now.min >= 7'd59) begin
                nxt.min = '0;
                if (now.hr >= 5'd23) begin
                    nxt.hr   = '0;
                    nxt.wday = (now.wday >= 3'd6) ? 3'd0 : now.wday + 3'd1;
                    if (now.mday >= dim) begin
                        nxt.mday = 5'd1;
                        if (now.mon >= 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt.year = now.year + 12'd1;
                        end else begin
                            nxt.mon = now.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = now.mday + 5'd1;
                    end
                end else begin
                    nxt.hr = now.hr + 5'd1;
                end
            end else begin
                nxt.min = now.min + 7'd1;
            end
        end else begin
            nxt.sec = now.sec + 7'd1;
        end
    end

    // Time register: reset, load or advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '{sec: '0, min: '0, hr: '0, wday: '0, mday: 5'd1, mon: 4'd1,
                     year: 12'(YEAR_BASE)};
        end else if (ld) begin
            now <= ld_time;
        end else if (adv) begin
            now <= nxt;
        end
    end

    // R1
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && now.sec == 7'd59) |=> (now.sec == 7'd0));
    // R1
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && now.sec < 7'd59) |=> (now.sec == $past(now.sec) + 7'd1));
    // R3
    leap_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld && leap && now.mon == 4'd2 && now.mday == 5'd28 &&
         now.hr == 5'd23 && now.min == 7'd59 && now.sec == 7'd59) |=> (now.mday == 5'd29));

endmodule

// File: rtl/rtc_cal_format.sv
// Turns the binary calendar into register bytes in packed-decimal or binary
// form and in 24-hour or 12-hour form. Purely combinational.
module rtc_cal_format
    import rtc_cal_pkg::*;
(
    input  cal_time_t  t,
    input  logic       bin,
    input  logic       h24,
    output logic [7:0] b_sec,
    output logic [7:0] b_min,
    output logic [7:0] b_hr,
    output logic [7:0] b_wday,
    output logic [7:0] b_mday,
    output logic [7:0] b_mon,
    output logic [7:0] b_year
);

    logic [11:0] yr100;
    logic [4:0]  h12;
    logic        pm;

    // Field encoding with 12-hour folding and two-digit year
    always_comb begin
        yr100  = t.year % 12'd100;
        pm     = (t.hr >= 5'd12);
        h12    = pm ? t.hr - 5'd12 : t.hr;
        b_sec  = enc_field(t.sec, bin);
        b_min  = enc_field(t.min, bin);
        b_hr   = h24 ? enc_field(7'(t.hr), bin)
                     : (enc_field(7'(h12), bin) | {pm, 7'd0});
        b_wday = enc_field(7'(t.wday), bin);
        b_mday = enc_field(7'(t.mday), bin);
        b_mon  = enc_field(7'(t.mon), bin);
        b_year = enc_field(yr100[6:0], bin);
    end

endmodule

// File: rtl/rtc_cal_alarm.sv
// Alarm comparator: each byte matches when it decodes to the current value
// or has bits 7:6 both set. The hour byte is compared as a 24-hour value.
module rtc_cal_alarm
    import rtc_cal_pkg::*;
(
    input  cal_time_t  t,
    input  logic       bin,
    input  logic [7:0] a_sec,
    input  logic [7:0] a_min,
    input  logic [7:0] a_hr,
    output logic       hit
);

    logic m_sec, m_min, m_hr;

    // Per-field match with wildcard
    always_comb begin
        m_sec = (a_sec[7:6] == 2'b11) || (dec_field(a_sec, bin) == t.sec);
        m_min = (a_min[7:6] == 2'b11) || (dec_field(a_min, bin) == t.min);
        m_hr  = (a_hr[7:6]  == 2'b11) || (dec_field(a_hr, bin) == 7'(t.hr));
        hit   = m_sec && m_min && m_hr;
    end

endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar counter top: gates the second tick on the divider field, runs the
// busy/publish update cycle DELAY_US microsecond ticks long, decodes loads and
// produces the status OR mask. Assumes a sec_tick never arrives with
// DELAY_US or fewer us_ticks left before the previous one.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DELAY_US  = 244,
    parameter int YEAR_BASE = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       us_tick,
    input  logic [2:0] div_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       upd_ie,
    input  logic       alarm_ie,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hr,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       busy,
    output logic [7:0] flag_or
);

    localparam int CW = (DELAY_US > 1) ? $clog2(DELAY_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_US - 1);
    localparam logic [7:0] ALARM_MASK = 8'hA0;
    localparam logic [7:0] UPD_MASK   = 8'h90;

    cal_time_t     now, ld_time;
    logic          counted, fire, pend, hit;
    logic [CW-1:0] cnt;
    logic [6:0]    d_sec, d_min, d_hraw, d_hsum, d_wday, d_mday, d_mon, d_year;
    logic [7:0]    f_sec, f_min, f_hr, f_wday, f_mday, f_mon, f_year;

    // Decode the load bytes in the current number and hour form
    always_comb begin
        d_sec   = dec_field(ld_sec, bin_mode);
        d_min   = dec_field(ld_min, bin_mode);
        d_hraw  = dec_field({1'b0, ld_hr[6:0]}, bin_mode);
        d_hsum  = d_hraw + ((!h24_mode && ld_hr[7]) ? 7'd12 : 7'd0);
        d_wday  = dec_field(ld_wday, bin_mode);
        d_mday  = dec_field(ld_mday, bin_mode);
        d_mon   = dec_field(ld_mon, bin_mode);
        d_year  = dec_field(ld_year, bin_mode);
        ld_time = '{sec: d_sec, min: d_min, hr: d_hsum[4:0], wday: d_wday[2:0],
                    mday: d_mday[4:0], mon: d_mon[3:0],
                    year: 12'(YEAR_BASE) + 12'(d_year)};
    end

    // Tick gating and end-of-cycle strobe
    always_comb begin
        counted = sec_tick && (div_sel == DIV_RUN) && !load_en;
        fire    = pend && us_tick && (cnt == LAST) && !counted;
    end

    rtc_cal_counter #(.YEAR_BASE(YEAR_BASE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(counted), .ld(load_en),
        .ld_time(ld_time), .now(now)
    );

    rtc_cal_format u_fmt (
        .t(now), .bin(bin_mode), .h24(h24_mode),
        .b_sec(f_sec), .b_min(f_min), .b_hr(f_hr), .b_wday(f_wday),
        .b_mday(f_mday), .b_mon(f_mon), .b_year(f_year)
    );

    rtc_cal_alarm u_alm (
        .t(now), .bin(bin_mode), .a_sec(alm_sec), .a_min(alm_min),
        .a_hr(alm_hr), .hit(hit)
    );

    // Update-cycle sequencer: busy, delay count, flag mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            cnt     <= '0;
            busy    <= 1'b0;
            flag_or <= '0;
        end else begin
            flag_or <= '0;
            if (counted) begin
                pend <= 1'b1;
                cnt  <= '0;
                if (!set_mode) busy <= 1'b1;
            end else if (pend && us_tick) begin
                if (cnt == LAST) begin
                    pend    <= 1'b0;
                    busy    <= 1'b0;
                    flag_or <= ((alarm_ie && hit) ? ALARM_MASK : 8'h00) |
                               ((upd_ie && !set_mode) ? UPD_MASK : 8'h00);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Published time bytes: loaded raw or copied at end of cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sec_o, min_o, hr_o, wday_o} <= '0;
            {mday_o, mon_o, year_o}      <= {8'h01, 8'h01, 8'h00};
        end else if (load_en) begin
            {sec_o, min_o, hr_o, wday_o, mday_o, mon_o, year_o} <=
                {ld_sec, ld_min, ld_hr, ld_wday, ld_mday, ld_mon, ld_year};
        end else if (fire && !set_mode) begin
            {sec_o, min_o, hr_o, wday_o, mday_o, mon_o, year_o} <=
                {f_sec, f_min, f_hr, f_wday, f_mday, f_mon, f_year};
        end
    end

    // R4
    div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && div_sel != DIV_RUN && !busy) |=> !busy);
    // R6
    set_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(set_mode));
    // R12
    flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_or != 8'h00) |=> (flag_or == 8'h00));
    // R5
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_or != 8'h00) |-> !busy);

endmodule

// File: tb/tb_rtc_calendar_core.sv
// Scoreboard bench: the tick task advances a reference calendar and queues the
// expected bytes; the monitor compares them at every falling edge of busy.
module tb_rtc_calendar_core;

    localparam int DLY = 244;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sec_tick = 0, us_tick = 1, set_mode = 0, bin_mode = 0, h24_mode = 1;
    logic       upd_ie = 0, alarm_ie = 0, load_en = 0;
    logic [2:0] div_sel = 3'b010;
    logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hr = 0, ld_wday = 0, ld_mday = 0, ld_mon = 0, ld_year = 0;
    logic [7:0] sec_o, min_o, hr_o, wday_o, mday_o, mon_o, year_o, flag_or;
    logic       busy;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference calendar and alarm settings (-1 = wildcard)
    int m_sec = 0, m_min = 0, m_hr = 0, m_wd = 0, m_md = 1, m_mo = 1, m_yr = 2000;
    int a_sec = 0, a_min = 0, a_hr = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    rtc_calendar_core #(.DELAY_US(DLY), .YEAR_BASE(2000)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .us_tick(us_tick),
        .div_sel(div_sel), .set_mode(set_mode), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .upd_ie(upd_ie), .alarm_ie(alarm_ie),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr),
        .ld_wday(ld_wday), .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
        .busy(busy), .flag_or(flag_or)
    );

    function automatic logic [7:0] enc(int v);
        return bin_mode ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_hr(int h);
        if (h24_mode) return enc(h);
        return enc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return ((yr % 4 == 0) && ((yr % 100 != 0) || (yr % 400 == 0))) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] model_bytes();
        return {enc(m_sec), enc(m_min), enc_hr(m_hr), enc(m_wd), enc(m_md), enc(m_mo), enc(m_yr % 100)};
    endfunction

    function automatic logic [55:0] dut_bytes();
        return {sec_o, min_o, hr_o, wday_o, mday_o, mon_o, year_o};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_adv();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_wd = (m_wd == 6) ? 0 : m_wd + 1;
                    m_md++;
                    if (m_md > days_in(m_mo, m_yr)) begin
                        m_md = 1; m_mo++;
                        if (m_mo == 13) begin m_mo = 1; m_yr++; end
                    end
                end
            end
        end
    endtask

    function automatic logic [7:0] alm_byte(int v);
        return (v < 0) ? 8'hC0 : enc(v);
    endfunction

    // Driver: one second tick, queues the expected publish
    task automatic tick(string tag);
        logic [7:0] fl;
        bit hit;
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        if (div_sel == 3'b010) begin
            model_adv();
            hit = ((a_sec < 0) || a_sec == m_sec) && ((a_min < 0) || a_min == m_min) &&
                  ((a_hr < 0) || a_hr == m_hr);
            fl = ((alarm_ie && hit) ? 8'hA0 : 8'h00) | ((upd_ie && !set_mode) ? 8'h90 : 8'h00);
            if (!set_mode) begin
                exp_q.push_back({model_bytes(), fl});
                tag_q.push_back(tag);
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        check("drain", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic load(int s, int mi, int h, int wd, int md, int mo, int yr);
        m_sec = s; m_min = mi; m_hr = h; m_wd = wd; m_md = md; m_mo = mo; m_yr = yr;
        @(negedge clk);
        {ld_sec, ld_min, ld_hr, ld_wday, ld_mday, ld_mon, ld_year} = model_bytes();
        load_en = 1;
        @(negedge clk); load_en = 0;
    endtask

    task automatic set_alarm(int s, int mi, int h);
        a_sec = s; a_min = mi; a_hr = h;
        alm_sec = alm_byte(s); alm_min = alm_byte(mi); alm_hr = alm_byte(h);
    endtask

    // Monitor: compares at each end of an update cycle
    logic prev_busy = 0;
    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6: unexpected publish actual %h expected none", {dut_bytes(), flag_or});
            end else begin
                check(tag_q.pop_front(), {dut_bytes(), flag_or}, exp_q.pop_front());
            end
        end
        prev_busy = busy;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [55:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13: reset state
        check("R13", {dut_bytes(), flag_or, 7'd0, busy}, {56'h00000000010100, 8'h00, 8'h00});

        // R5: busy length equals DELAY_US us ticks, then publish (R1 step)
        tick("R5");
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R5", 64'(n), 64'(DLY));
        drain();

        // R1 and R2: full rollover through year end, weekday 6 to 0
        load(59, 59, 23, 6, 31, 12, 2099);
        tick("R2"); drain();
        // R2: thirty-day month
        load(59, 59, 23, 2, 30, 4, 2023);
        tick("R2"); drain();
        // R3: leap years by 400 and by 4, common year
        load(59, 59, 23, 1, 28, 2, 2000);
        tick("R3"); drain();
        load(59, 59, 23, 3, 29, 2, 2024);
        tick("R3"); drain();
        load(59, 59, 23, 4, 28, 2, 2023);
        tick("R3"); drain();
        // R1: minute and hour carry without day change
        load(59, 59, 9, 0, 10, 6, 2030);
        tick("R1"); drain();

        // R7: binary byte form
        bin_mode = 1;
        load(59, 20, 10, 2, 17, 8, 2042);
        tick("R7"); drain();
        bin_mode = 0;

        // R8: 12-hour form, 11 AM to noon and 11 PM to midnight
        h24_mode = 0;
        load(59, 59, 11, 1, 5, 3, 2031);
        tick("R8"); drain();
        // R9: PM bit on load adds 12 hours
        load(59, 59, 23, 1, 5, 3, 2031);
        check("R9", {8'h00, dut_bytes()}, {8'h00, 56'h59599101050331});
        tick("R9"); drain();
        h24_mode = 1;

        // R9: load wins over a simultaneous tick
        m_sec = 30; m_min = 15; m_hr = 8; m_wd = 3; m_md = 12; m_mo = 7; m_yr = 2015;
        @(negedge clk);
        {ld_sec, ld_min, ld_hr, ld_wday, ld_mday, ld_mon, ld_year} = model_bytes();
        load_en = 1; sec_tick = 1;
        @(negedge clk); load_en = 0; sec_tick = 0;
        check("R9", {7'd0, busy, dut_bytes()}, {8'h00, model_bytes()});
        tick("R9"); drain();

        // R4: divider not running, tick ignored
        held = dut_bytes();
        div_sel = 3'b000;
        tick("R4");
        check("R4", {7'd0, busy, 56'd0}, 64'd0);
        repeat (300) @(negedge clk);
        check("R4", {8'h00, dut_bytes()}, {8'h00, held});
        div_sel = 3'b010;
        tick("R4"); drain();

        // R6: set mode freezes publishing but counting goes on
        held = dut_bytes();
        set_mode = 1;
        tick("R6");
        check("R6", {7'd0, busy, 56'd0}, 64'd0);
        repeat (300) @(negedge clk);
        check("R6", {8'h00, dut_bytes()}, {8'h00, held});
        set_mode = 0;
        tick("R6"); drain();

        // R10: alarm match on seconds and minutes, hour wildcard
        alarm_ie = 1;
        set_alarm(0, 1, -1);
        load(59, 0, 5, 2, 9, 9, 2029);
        tick("R10"); drain();
        // R12: mask gone one cycle later
        @(negedge clk);
        check("R12", {56'd0, flag_or}, 64'd0);
        // R10: mismatch gives no alarm mask
        set_alarm(30, -1, -1);
        tick("R10"); drain();
        // R11: update-ended with alarm wildcards, combined B0
        upd_ie = 1;
        set_alarm(-1, -1, -1);
        tick("R11"); drain();
        alarm_ie = 0;
        tick("R11"); drain();
        upd_ie = 0;

        repeat (5) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule